// File: doc/BRIEF.md
# Conversion Start Controller

This block sits between the asynchronous control pins of a successive-approximation converter and its internal bit sequencer. It watches four control inputs: an active-high enable, an active-low select, a read/convert line and a byte-address line. It also watches a sampling-mode pin. When enable is high, select is low and read/convert is low all at the same time, the block issues exactly one start pulse to the sequencer. The pulse comes from the transition that completes this condition, whichever of the three inputs moved last. At each such transition the block captures the byte-address line as the conversion-length choice: high asks for an 8-bit conversion and low asks for a 12-bit one.

While a conversion is under way, further start transitions cannot launch or abort a conversion. They still re-capture the length choice. In direct mode the hold indication and the start pulse appear together. In delayed mode the block first waits a fixed number of clock cycles, leaving the input in sampling, and then starts. A host can also run the converter with enable tied high, select tied low and byte-address tied low, so that a falling edge on read/convert alone starts a 12-bit conversion.

Top module: `cvs_start_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, start_pulse, hold_active and len_short are all 0.
- R2: start_pulse is high for exactly one clock cycle, three rising edges after an input change that makes chip_en=1, chip_sel_n=0, rd_conv=0 true. This holds whether rd_conv, chip_sel_n or chip_en moved last, and when all three change together.
- R3: Input changes that never make all three start conditions true together produce no start_pulse.
- R4: len_short takes the value of byte_addr (1 = 8-bit, 0 = 12-bit) from the start transition, with the same three-edge latency as start_pulse.
- R5: While hold_active, seq_busy or the acquisition delay is active, a start transition produces no start_pulse.
- R6: A start transition that is refused under R5 still updates len_short to the byte_addr value it sees.
- R7: In direct mode (emul_mode=0), hold_active rises in the same cycle as start_pulse.
- R8: In delayed mode (emul_mode=1), start_pulse and the rise of hold_active come ACQ_CYCLES cycles after the point where direct mode would have started. hold_active stays 0 during the delay.
- R9: A start transition during the delayed-mode wait neither adds a pulse nor restarts the delay. It does change the length reported with the pending start.
- R10: hold_active falls one cycle after seq_busy falls.
- R11: With chip_en=1, chip_sel_n=0 and byte_addr=0 held, each falling edge of rd_conv gives one 12-bit start (len_short=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en | input | 1 | Enable, active high, asynchronous |
| chip_sel_n | input | 1 | Select, active low, asynchronous |
| rd_conv | input | 1 | Read (1) / convert (0), asynchronous |
| byte_addr | input | 1 | Length choice at start: 1 = 8-bit, 0 = 12-bit |
| emul_mode | input | 1 | 1 = delayed acquisition before start, 0 = direct start |
| seq_busy | input | 1 | Sequencer is converting |
| start_pulse | output | 1 | One-cycle start command to the sequencer |
| len_short | output | 1 | Captured length choice, 1 = 8-bit |
| hold_active | output | 1 | Input held (1) or sampling (0) |

## Verification
If the previous-condition register or a synchroniser stage were wrong, a start would show at the ports as a missing, doubled or early pulse. The scoreboard would see this within three cycles of the stimulus, because it matches each pulse against the exact cycle predicted for it. A lockout that is too weak shows up as an extra pulse during a running conversion. A length latch that is wrongly gated shows up as a wrong len_short either three cycles after a refused start or at the pending delayed start. A timer that is off by one moves the delayed pulse by a cycle, and a hold flag that clears at the wrong time is visible one cycle after seq_busy falls.

// File: rtl/cvs_pkg.sv
package cvs_pkg;

  // Control inputs gathered into one vector so they can be synchronised together.
  typedef struct packed {
    logic ce;
    logic cs_n;
    logic rc;
    logic a0;
    logic emul;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  // Reset value of the synchroniser: a pin state that cannot start anything.
  localparam ctl_t CTL_IDLE = '{ce: 1'b0, cs_n: 1'b1, rc: 1'b1, a0: 1'b0, emul: 1'b0};

  typedef enum logic {
    LEN_FULL  = 1'b0,
    LEN_SHORT = 1'b1
  } len_e;

  function automatic logic start_cond(input ctl_t c);
    return c.ce & ~c.cs_n & ~c.rc;
  endfunction

endpackage

// File: rtl/cvs_sync.sv
module cvs_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/cvs_start_detect.sv
module cvs_start_detect
  import cvs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  ctl_t ctl_s,
  output logic trig
);

  logic cond_now;
  logic cond_q;

  assign cond_now = start_cond(ctl_s);

  always_ff @(posedge clk) begin
    if (rst) cond_q <= 1'b0;
    else     cond_q <= cond_now;
  end

  // One cycle high on the transition that completes the condition.
  assign trig = cond_now & ~cond_q;

endmodule

// File: rtl/cvs_acq_timer.sv
module cvs_acq_timer #(
  parameter int ACQ_CYCLES = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic active,
  output logic expire
);

  localparam int CW = $clog2(ACQ_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(ACQ_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (load) begin
      cnt    <= LAST;
      active <= 1'b1;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  assign expire = active & (cnt == '0);

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt <= LAST));

endmodule

// File: rtl/cvs_start_ctrl.sv
module cvs_start_ctrl
  import cvs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ACQ_CYCLES  = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic chip_en,
  input  logic chip_sel_n,
  input  logic rd_conv,
  input  logic byte_addr,
  input  logic emul_mode,
  input  logic seq_busy,
  output logic start_pulse,
  output logic len_short,
  output logic hold_active
);

  ctl_t             raw;
  ctl_t             syn;
  logic [CTL_W-1:0] syn_bits;
  logic             trig;
  logic             lockout;
  logic             tmr_load;
  logic             tmr_active;
  logic             tmr_expire;
  logic             start_nxt;
  logic             busy_d;
  logic             start_q;
  logic             hold_q;
  len_e             len_q;

  assign raw = '{ce: chip_en, cs_n: chip_sel_n, rc: rd_conv, a0: byte_addr, emul: emul_mode};

  cvs_sync #(
    .W       (CTL_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (CTL_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (raw),
    .dout (syn_bits)
  );

  assign syn = ctl_t'(syn_bits);

  cvs_start_detect u_detect (
    .clk   (clk),
    .rst   (rst),
    .ctl_s (syn),
    .trig  (trig)
  );

  // A conversion is in flight, pending or just launched.
  assign lockout  = seq_busy | tmr_active | hold_q;
  assign tmr_load = trig & ~lockout & syn.emul;

  cvs_acq_timer #(
    .ACQ_CYCLES (ACQ_CYCLES)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load   (tmr_load),
    .active (tmr_active),
    .expire (tmr_expire)
  );

  assign start_nxt = (trig & ~lockout & ~syn.emul) | tmr_expire;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      hold_q  <= 1'b0;
      len_q   <= LEN_FULL;
      busy_d  <= 1'b0;
    end else begin
      start_q <= start_nxt;
      busy_d  <= seq_busy;
      if (trig) len_q <= len_e'(syn.a0);
      if (start_nxt)              hold_q <= 1'b1;
      else if (busy_d & ~seq_busy) hold_q <= 1'b0;
    end
  end

  assign start_pulse = start_q;
  assign hold_active = hold_q;
  assign len_short   = len_q;

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q);

  assert_len_on_trig_R4: assert property (@(posedge clk) disable iff (rst)
    !trig |=> $stable(len_q));

  assert_hold_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    hold_q |=> !start_q);

  assert_busy_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    (seq_busy && !tmr_active) |=> !start_q);

  assert_pulse_with_hold_R7: assert property (@(posedge clk) disable iff (rst)
    start_q |-> hold_q);

  assert_delay_no_reload_R9: assert property (@(posedge clk) disable iff (rst)
    tmr_expire |=> !tmr_active);

  assert_hold_release_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_q) |-> !$past(seq_busy));

endmodule

// File: tb/sim_cvs_start_ctrl.sv
`timescale 1ns/1ps
module sim_cvs_start_ctrl;

  localparam int ACQ  = 16;
  localparam int CONV = 30;
  localparam int LAT  = 3;

  typedef struct {
    int   at;
    logic len;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chip_en = 1'b0, chip_sel_n = 1'b1, rd_conv = 1'b1, byte_addr = 1'b0, emul_mode = 1'b0;
  logic seq_busy = 1'b0;
  logic start_pulse, len_short, hold_active;

  int   cyc = 0;
  int   bcnt = 0;
  int   checks = 0;
  int   fails = 0;
  int   n_pulses = 0;
  exp_t exp_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cvs_start_ctrl #(.SYNC_STAGES(2), .ACQ_CYCLES(ACQ)) u0 (
    .clk(clk), .rst(rst), .chip_en(chip_en), .chip_sel_n(chip_sel_n),
    .rd_conv(rd_conv), .byte_addr(byte_addr), .emul_mode(emul_mode),
    .seq_busy(seq_busy), .start_pulse(start_pulse), .len_short(len_short),
    .hold_active(hold_active)
  );

  // Sequencer model: busy for CONV cycles after each start.
  always @(posedge clk) begin
    if (rst) begin
      bcnt <= 0; seq_busy <= 1'b0;
    end else if (start_pulse) begin
      bcnt <= CONV; seq_busy <= 1'b1;
    end else if (bcnt > 1) begin
      bcnt <= bcnt - 1;
    end else if (bcnt == 1) begin
      bcnt <= 0; seq_busy <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // Monitor: every start pulse must match the oldest expected item.
  always @(negedge clk) begin
    if (!rst && start_pulse) begin
      n_pulses++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected start", cyc, -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(cyc == e.at, "R2 start cycle", cyc, e.at);
        chk(len_short == e.len, "R4 length at start", len_short, e.len);
        chk(hold_active == 1'b1, "R7 hold with start", hold_active, 1);
      end
    end
  end

  task automatic drive(input logic ce, input logic csn, input logic rc, input logic a0, input logic md);
    @(posedge clk); #1;
    chip_en = ce; chip_sel_n = csn; rd_conv = rc; byte_addr = a0; emul_mode = md;
  endtask

  task automatic expect_start(input int at, input logic ln);
    exp_t e;
    e.at = at; e.len = ln;
    exp_q.push_back(e);
  endtask

  task automatic wait_idle;
    repeat (5) @(posedge clk);
    while (hold_active || seq_busy || exp_q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int c;
    int p;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!start_pulse && !hold_active && !len_short, "R1 in reset",
        {start_pulse, hold_active, len_short}, 0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk(!start_pulse && !hold_active && !len_short, "R1 after reset",
        {start_pulse, hold_active, len_short}, 0);

    // R2: rd_conv moves last, 12-bit; R10 hold release timing
    drive(1, 0, 1, 0, 0);
    repeat (4) @(posedge clk);
    drive(1, 0, 0, 0, 0); expect_start(cyc + LAT, 1'b0);
    @(negedge seq_busy);
    @(negedge clk); chk(hold_active == 1'b1, "R10 hold before release", hold_active, 1);
    @(negedge clk); chk(hold_active == 1'b0, "R10 hold released", hold_active, 0);
    wait_idle; drive(0, 1, 1, 0, 0); wait_idle;

    // R2/R4: chip_sel_n moves last, 8-bit
    drive(1, 1, 0, 1, 0);
    repeat (4) @(posedge clk);
    drive(1, 0, 0, 1, 0); expect_start(cyc + LAT, 1'b1);
    wait_idle; drive(0, 1, 1, 0, 0); wait_idle;

    // R2: chip_en moves last, 12-bit
    drive(0, 0, 0, 0, 0);
    repeat (4) @(posedge clk);
    drive(1, 0, 0, 0, 0); expect_start(cyc + LAT, 1'b0);
    wait_idle; drive(0, 1, 1, 0, 0); wait_idle;

    // R2: all three together, 8-bit
    drive(1, 0, 0, 1, 0); expect_start(cyc + LAT, 1'b1);
    wait_idle; drive(0, 1, 1, 0, 0); wait_idle;

    // R3: partial conditions only
    p = n_pulses;
    drive(1, 1, 0, 0, 0);
    drive(0, 0, 0, 0, 0);
    drive(1, 1, 1, 0, 0);
    drive(0, 0, 1, 0, 0);
    drive(1, 0, 1, 0, 0);
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(n_pulses == p, "R3 no start on partial condition", n_pulses - p, 0);
    drive(0, 1, 1, 0, 0); wait_idle;

    // R5/R6: restart during conversion re-captures length only
    drive(1, 0, 1, 0, 0);
    repeat (3) @(posedge clk);
    drive(1, 0, 0, 0, 0); expect_start(cyc + LAT, 1'b0);
    repeat (8) @(posedge clk);
    drive(1, 0, 1, 1, 0);
    drive(1, 0, 0, 1, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(len_short == 1'b1, "R6 length re-captured while busy", len_short, 1);
    p = n_pulses;
    wait_idle;
    chk(n_pulses == p, "R5 no start while busy", n_pulses - p, 0);
    chk(len_short == 1'b1, "R6 length kept", len_short, 1);
    drive(0, 1, 1, 0, 0); wait_idle;

    // R11: stand-alone, rd_conv edges only
    drive(1, 0, 1, 0, 0);
    repeat (4) @(posedge clk);
    drive(1, 0, 0, 0, 0); expect_start(cyc + LAT, 1'b0);
    wait_idle;
    drive(1, 0, 1, 0, 0);
    repeat (4) @(posedge clk);
    drive(1, 0, 0, 0, 0); expect_start(cyc + LAT, 1'b0);
    wait_idle;
    chk(len_short == 1'b0, "R11 stand-alone length", len_short, 0);

    // R8/R9: delayed mode, second command during the wait
    drive(1, 0, 1, 0, 1);
    repeat (4) @(posedge clk);
    drive(1, 0, 0, 0, 1); c = cyc;
    expect_start(c + LAT + ACQ, 1'b1);
    repeat (4) @(posedge clk);
    drive(1, 0, 1, 1, 1);
    drive(1, 0, 0, 1, 1);
    @(negedge clk);
    chk(hold_active == 1'b0, "R8 sampling during delay", hold_active, 0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(hold_active == 1'b0 && exp_q.size() == 1, "R9 no early start",
        exp_q.size(), 1);
    wait_idle;
    drive(0, 1, 1, 0, 0); wait_idle;

    chk(exp_q.size() == 0, "R2 all expected starts seen", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule